// File: doc/BRIEF.md
# Correlating two-bit branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters that hardware trains as branches resolve. The table is indexed by low-order bits of the branch address. Each table entry holds a pair of two-bit counters. A global history bit records the outcome of the most recently resolved branch, and that bit selects which counter of the pair is read and trained. A branch whose direction depends on the previous branch, such as a strict taken/not-taken alternation, therefore trains two separate counters. A single counter per address would keep flipping on such a branch.

The fetch side presents a program counter on the lookup port and receives a direction guess combinationally in the same cycle. The execute side reports each resolved branch on the training port, giving its address and actual direction. On the next clock edge the selected counter moves one step toward that direction, and the outcome is shifted into the history. Several branches may share an entry; this aliasing is accepted.

Top module: `corr_branch_predictor`

## Requirements
- R1: The guess is combinational: `pred_taken` is the upper bit of the counter picked by entry index `pred_pc[IDX_W+1:2]` and by the current history value, with no clock between lookup and result.
- R2: Counters use the codes 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken outcome raises the trained counter by one and a not-taken outcome lowers it by one.
- R3: Counters saturate: a taken outcome at 11 and a not-taken outcome at 00 leave the counter unchanged.
- R4: After reset every counter holds 01, so every lookup returns not-taken, and the history bit is 0.
- R5: On each accepted update (`upd_valid` high at a clock edge) the history takes the reported outcome (1 for taken). Without an update it holds.
- R6: An update trains only the counter selected by entry index `upd_pc[IDX_W+1:2]` and by the history value before that update. The other counter of the pair and all other entries are left as they were.
- R7: When an update and a lookup hit the same entry in one cycle, the lookup returns the value from before the update; the new value is visible from the next cycle.
- R8: Address bits below bit 2 and above bit IDX_W+1 play no part: addresses that share bits [IDX_W+1:2] read and train the same entry.
- R9: Once a counter sits at a strong state, one contrary outcome does not change its guess; a second consecutive contrary outcome does.
- R10: For a branch that strictly alternates taken and not-taken, with no other branches in between, the predictor guesses every outcome correctly after a short warm-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Direction guess for `pred_pc`, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The assertions assume that `upd_valid`, `upd_pc` and `upd_taken` are known and steady around each rising edge. They also assume a lookup address that does not change between edges, so a prediction can be compared with the one before it. The bench drives every input only on the falling edge, holds it through the following rising edge, and deasserts `upd_valid` in idle cycles. That keeps stimulus inside these assumptions. Directed runs place contrary outcomes on a second, unrelated entry to set the history bit to a known value. This lets each counter of a pair be saturated, stepped and flipped on its own.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Two-bit saturating direction counter; MSB is the guess.
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_NT   = 2'b01;
   localparam ctr_t CTR_WEAK_TK   = 2'b10;
   localparam ctr_t CTR_STRONG_TK = 2'b11;

   // Value every counter takes at reset.
   localparam ctr_t CTR_RESET     = CTR_WEAK_NT;

endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
   import bp_pkg::*;
(
   input  ctr_t cur,
   input  logic taken,
   output ctr_t nxt
);

   always_comb begin
      nxt = cur;
      if (taken) begin
         if (cur != CTR_STRONG_TK) nxt = cur + 2'd1;
      end else begin
         if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
      end
   end

endmodule

// File: rtl/bp_history.sv
module bp_history #(
   parameter int HIST_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              outcome,
   output logic [HIST_W-1:0] hist
);

   generate
      if (HIST_W < 1) begin : g_bad_width
         $error("bp_history: HIST_W must be at least 1");
      end
   endgenerate

   logic [HIST_W-1:0] hist_q;

   generate
      if (HIST_W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= outcome;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
         end
      end
   endgenerate

   assign hist = hist_q;

   // R5: newest history bit equals the last reported outcome
   p_hist_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist_q[0] == $past(outcome));

   // R5: history holds when no update is reported
   p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int HIST_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [HIST_W-1:0] rd_sel,
   output ctr_t              rd_ctr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [HIST_W-1:0] wr_sel,
   input  logic              wr_taken
);

   localparam int ENTRIES = 1 << IDX_W;
   localparam int CPE     = 1 << HIST_W;

   generate
      if (ENTRIES * CPE > 4096) begin : g_too_big
         $error("bp_ctr_table: table exceeds 4096 counters");
      end
   endgenerate

   ctr_t mem [ENTRIES][CPE];
   ctr_t wr_old;
   ctr_t wr_new;

   assign wr_old = mem[wr_idx][wr_sel];
   assign rd_ctr = mem[rd_idx][rd_sel];

   bp_ctr_step u_step (
      .cur   (wr_old),
      .taken (wr_taken),
      .nxt   (wr_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++)
            for (int c = 0; c < CPE; c++)
               mem[e][c] <= CTR_RESET;
      end else if (wr_en) begin
         mem[wr_idx][wr_sel] <= wr_new;
      end
   end

   // R3: strong taken stays strong taken on a taken outcome
   p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && wr_old == CTR_STRONG_TK)
      |=> mem[$past(wr_idx)][$past(wr_sel)] == CTR_STRONG_TK);

   // R3: strong not-taken stays put on a not-taken outcome
   p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && wr_old == CTR_STRONG_NT)
      |=> mem[$past(wr_idx)][$past(wr_sel)] == CTR_STRONG_NT);

   // R2: a taken outcome below saturation raises the counter by one
   p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && wr_old != CTR_STRONG_TK)
      |=> mem[$past(wr_idx)][$past(wr_sel)] == ctr_t'($past(wr_old) + 2'd1));

   // R2: a not-taken outcome above saturation lowers the counter by one
   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && wr_old != CTR_STRONG_NT)
      |=> mem[$past(wr_idx)][$past(wr_sel)] == ctr_t'($past(wr_old) - 2'd1));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
   import bp_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int IDX_W  = 6,
   parameter int HIST_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int IDX_LO = 2;
   localparam int IDX_HI = IDX_W + IDX_LO - 1;

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("corr_branch_predictor: IDX_W must be at least 1");
      end
      if (PC_W <= IDX_HI + 1) begin : g_bad_pc
         $error("corr_branch_predictor: PC_W must exceed IDX_W + 2");
      end
   endgenerate

   logic [IDX_W-1:0]  pred_idx;
   logic [IDX_W-1:0]  upd_idx;
   logic [HIST_W-1:0] hist;
   ctr_t              pred_ctr;
   logic              unused_pc_bits;

   assign pred_idx = pred_pc[IDX_HI:IDX_LO];
   assign upd_idx  = upd_pc[IDX_HI:IDX_LO];
   assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI+1], pred_pc[IDX_LO-1:0],
                             upd_pc[PC_W-1:IDX_HI+1],  upd_pc[IDX_LO-1:0]};

   bp_history #(
      .HIST_W (HIST_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .outcome  (upd_taken),
      .hist     (hist)
   );

   bp_ctr_table #(
      .IDX_W  (IDX_W),
      .HIST_W (HIST_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (pred_idx),
      .rd_sel   (hist),
      .rd_ctr   (pred_ctr),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_sel   (hist),
      .wr_taken (upd_taken)
   );

   assign pred_taken = pred_ctr[1];

   // R1: with no training and an unchanged lookup address the guess holds
   p_noupd_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> (!$stable(pred_pc) || $stable(pred_taken)));

endmodule

// File: tb/corr_branch_predictor_tb.sv
module corr_branch_predictor_tb;

   localparam int PC_W  = 32;
   localparam int IDX_W = 6;
   localparam int ENT   = 1 << IDX_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] pred_pc = '0;
   logic            pred_taken;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;

   int errors = 0;
   int checks = 0;
   int m_ctr [ENT][2];
   int m_hist = 0;

   always #5 clk = ~clk;

   corr_branch_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(1)) u_dut (
      .clk, .rst_n, .pred_pc, .pred_taken, .upd_valid, .upd_pc, .upd_taken
   );

   function automatic int idx_of(input logic [PC_W-1:0] pc);
      return int'((pc >> 2) % ENT);
   endfunction

   function automatic int m_pred(input logic [PC_W-1:0] pc);
      return (m_ctr[idx_of(pc)][m_hist] >= 2) ? 1 : 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: pred_taken=%0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic m_train(input logic [PC_W-1:0] pc, input logic t);
      int c;
      c = m_ctr[idx_of(pc)][m_hist];
      if (t) c = (c < 3) ? c + 1 : 3;
      else   c = (c > 0) ? c - 1 : 0;
      m_ctr[idx_of(pc)][m_hist] = c;
      m_hist = t ? 1 : 0;
   endtask

   // One cycle: drive at falling edge, compare before rising edge, advance model.
   task automatic step(input logic [PC_W-1:0] ppc, input logic uv,
                       input logic [PC_W-1:0] upc, input logic ut,
                       input string tag, input int exp);
      @(negedge clk);
      pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
      #1;
      chk("R1 model", int'(pred_taken), m_pred(ppc));
      if (exp >= 0) chk(tag, int'(pred_taken), exp);
      @(posedge clk);
      if (uv) m_train(upc, ut);
   endtask

   task automatic peek(input logic [PC_W-1:0] pc, input string tag, input int exp);
      step(pc, 1'b0, '0, 1'b0, tag, exp);
   endtask

   task automatic train(input logic [PC_W-1:0] pc, input logic t);
      step(pc, 1'b1, pc, t, "", -1);
   endtask

   localparam logic [PC_W-1:0] PA = 32'h0000_0104;
   localparam logic [PC_W-1:0] PB = 32'h0000_0208;
   localparam logic [PC_W-1:0] PC = 32'h0000_030C;
   localparam logic [PC_W-1:0] PD = 32'h0000_0410;
   localparam logic [PC_W-1:0] PE = 32'h0000_0514;
   localparam logic [PC_W-1:0] PF = 32'h0000_0618;

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected end before timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int dut_miss;
      int sc;
      int sc_miss;
      logic [31:0] lfsr;
      for (int e = 0; e < ENT; e++) begin
         m_ctr[e][0] = 1;
         m_ctr[e][1] = 1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state, not-taken everywhere
      peek(PA, "R4", 0);
      peek(PB, "R4", 0);

      // R6: training uses the counter chosen by the pre-update history
      train(PA, 1'b1);            // A.sel0 01->10, hist 1
      peek(PA, "R6", 0);          // A.sel1 still 01
      train(PB, 1'b0);            // B.sel1 01->00, hist 0
      peek(PA, "R6", 1);          // A.sel0 now 10; R5 history followed outcome

      // R3 low saturation on A.sel0 (history stays 0)
      repeat (4) train(PA, 1'b0); // 10->01->00->00->00
      peek(PA, "R3", 0);
      train(PA, 1'b1);            // 00->01, hist 1
      train(PC, 1'b0);            // C.sel1, hist 0
      peek(PA, "R3", 0);          // 01 -> not-taken (wrap would give taken)

      // R3 high saturation on D.sel1
      train(PE, 1'b1);            // hist 1
      repeat (4) train(PD, 1'b1); // 01->10->11->11->11
      peek(PD, "R3", 1);

      // R9: two contrary outcomes needed to flip
      train(PD, 1'b0);            // D.sel1 11->10, hist 0
      train(PE, 1'b1);            // hist 1
      peek(PD, "R9", 1);
      train(PD, 1'b0);            // D.sel1 10->01
      train(PE, 1'b1);            // hist 1
      peek(PD, "R9", 0);

      // R7: same-cycle update and lookup sees old value
      step(PD, 1'b1, PD, 1'b1, "R7", 0);  // D.sel1 01->10, hist 1
      peek(PD, "R7", 1);

      // R8: aliasing and ignored address bits
      peek(PD + 32'h0000_0100, "R8", 1);
      peek(PD | 32'h0000_0003, "R8", 1);
      peek(PD | 32'h8000_0000, "R8", 1);

      // R10: alternating pattern on F
      dut_miss = 0; sc = 1; sc_miss = 0;
      for (int k = 0; k < 40; k++) begin
         logic t;
         t = (k % 2 == 1);
         @(negedge clk);
         pred_pc = PF; upd_valid = 1'b1; upd_pc = PF; upd_taken = t;
         #1;
         chk("R1 model", int'(pred_taken), m_pred(PF));
         if (k >= 8 && pred_taken != t) dut_miss++;
         if (k >= 8 && ((sc >= 2) != t)) sc_miss++;
         sc = t ? ((sc < 3) ? sc + 1 : 3) : ((sc > 0) ? sc - 1 : 0);
         @(posedge clk);
         m_train(PF, t);
      end
      chk("R10 mispredictions after warm-up", dut_miss, 0);
      $display("info: single-counter reference missed %0d of 32", sc_miss);

      // R1/R2: mixed traffic against the reference model
      lfsr = 32'h1357_9BDF;
      for (int n = 0; n < 400; n++) begin
         logic [PC_W-1:0] a, b;
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         a = {20'h0, lfsr[11:0]};
         b = (lfsr[20]) ? a : {20'h0, lfsr[27:16]};
         step(a, lfsr[29], b, lfsr[30] ^ lfsr[3], "", -1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule